// File: doc/BRIEF.md
# Timeslot-Window Pseudorandom Pattern Error Counter

This block sits behind the serial receiver of one TDM input stream. It watches a programmed run of consecutive timeslots in every frame, locks a local 15-stage reference generator onto the pseudorandom test pattern that arrives there, and counts every received bit that differs from the bit the reference predicts. The total is offered as a saturating error count that software reads and clears.

The host programs a start timeslot, a run length in timeslots, the stream rate and an enable bit. After enabling, the block waits for a frame pulse and then loads fifteen received window bits into the reference (state LOAD). It then compares each further window bit against the prediction (state TRACK). A burst of errors makes it drop lock and load the reference again. When disabled, it sits in state OFF. The states and their transitions:

- OFF: the checker is idle. It goes to ARM when the enable is high.
- ARM: it waits for the frame pulse, then goes to LOAD.
- LOAD: it goes to TRACK once fifteen window bits have been loaded.
- TRACK: it goes back to LOAD when too many errors arrive in a block of compared bits.
- From any state, a low enable sends it to OFF.

Top module: `prbs_window_checker`

## Requirements
- R1: After reset, `err_count` is 0 and the checker is in state OFF.
- R2: While `chk_en` is low, the count never changes except through `err_clr`, and the state returns to OFF. After enabling, nothing is compared until a `frame_pulse` has been seen.
- R3: A bit is used only in a cycle with `bit_stb` high and `chan_idx` in the range [`win_start`, `win_start` + `win_len`). A `win_len` of 0 uses no bits, and channels outside the window never change the count.
- R4: The channel count per frame is 32 shifted left by `rate_sel` (0: 32, 1: 64, 2: 128, 3: 256). The window end is clamped to that count, so channels at or above it are never used.
- R5: The first 15 window bits after arming, or after a loss of lock, are loaded into the reference and are not compared.
- R6: Each later window bit is compared with the prediction b[n-15] XOR b[n-14] (polynomial x^15 + x^14 + 1). The reference advances with its own prediction, so one flipped bit costs exactly one error.
- R7: Each mismatch raises `err_count` by exactly one.
- R8: `err_count` saturates at 2^CNT_W-1 and never wraps.
- R9: A one-cycle `err_clr` sets `err_count` to 0 on the next edge. It has priority over a coincident increment.
- R10: Compared bits are grouped in blocks of 64. Reaching 8 mismatches within one block drops lock and returns to LOAD. A block ends after its 64th bit or at a drop. Fewer than 8 errors keeps lock.
- R11: The reference state is kept across frames, so the pattern must continue from one frame's window into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pulse | input | 1 | Start-of-frame marker, one cycle |
| bit_stb | input | 1 | Serial bit valid in this cycle |
| chan_idx | input | CH_W | Timeslot number of the current bit |
| rx_bit | input | 1 | Received serial bit |
| rate_sel | input | RATE_W | Stream rate code |
| win_start | input | CH_W | First timeslot of the window |
| win_len | input | LEN_W | Window length in timeslots |
| chk_en | input | 1 | Checker enable |
| err_clr | input | 1 | Clear pulse for the error count |
| err_count | output | CNT_W | Saturating bit-error count |

## Verification
The properties assume that `err_clr` is a single-cycle pulse and that `win_start`, `win_len` and `rate_sel` stay constant while a frame is being received. The bench changes those registers only between frames and clears with one-cycle pulses. The frame pulse is always sent in a cycle without a bit strobe. A reference model fed only the window bits supplies the expected counts.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARM   = 2'd1,
        ST_LOAD  = 2'd2,
        ST_TRACK = 2'd3
    } pcw_state_e;

    localparam int unsigned BASE_CHANS = 32;
    localparam int unsigned PRBS_LEN   = 15;
endpackage

// File: rtl/pcw_window.sv
module pcw_window #(
    parameter int CH_W   = 8,
    parameter int LEN_W  = 9,
    parameter int RATE_W = 2,
    parameter int BASE   = 32
) (
    input  logic [CH_W-1:0]   chan_idx,
    input  logic [CH_W-1:0]   win_start,
    input  logic [LEN_W-1:0]  win_len,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              in_win
);
    localparam int SUM_W = ((CH_W > LEN_W) ? CH_W : LEN_W) + 1;

    logic [SUM_W-1:0] nch, win_end, end_c, chan_x, start_x;

    always_comb begin
        nch     = SUM_W'(BASE) << rate_sel;
        chan_x  = SUM_W'(chan_idx);
        start_x = SUM_W'(win_start);
        win_end = start_x + SUM_W'(win_len);
        end_c   = (win_end > nch) ? nch : win_end;
        in_win  = (chan_x >= start_x) && (chan_x < end_c);
    end
endmodule

// File: rtl/pcw_ref.sv
module pcw_ref #(
    parameter int W     = 15,
    parameter int TAP_A = 14,
    parameter int TAP_B = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic load_mode,
    input  logic rx_bit,
    output logic pred
);
    logic [W-1:0] sr_q;

    assign pred = sr_q[TAP_A] ^ sr_q[TAP_B];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[W-2:0], (load_mode ? rx_bit : pred)};
        end
    end
endmodule

// File: rtl/pcw_loss.sv
module pcw_loss #(
    parameter int WIN = 64,
    parameter int THR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cmp_stb,
    input  logic mism,
    output logic los
);
    localparam int BW = $clog2(WIN);
    localparam int EW = $clog2(THR + 1);

    logic [BW-1:0] bit_q;
    logic [EW-1:0] err_q, err_next;

    always_comb begin
        err_next = err_q + EW'(mism);
        los      = cmp_stb && (err_next >= EW'(THR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            err_q <= '0;
        end else if (restart) begin
            bit_q <= '0;
            err_q <= '0;
        end else if (cmp_stb) begin
            if (los || (bit_q == BW'(WIN - 1))) begin
                bit_q <= '0;
                err_q <= '0;
            end else begin
                bit_q <= bit_q + 1'b1;
                err_q <= err_next;
            end
        end
    end
endmodule

// File: rtl/pcw_errcnt.sv
module pcw_errcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != {W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/prbs_window_checker.sv
module prbs_window_checker
    import pcw_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CH_W    = 8,
    parameter int LEN_W   = 9,
    parameter int RATE_W  = 2,
    parameter int LOS_WIN = 64,
    parameter int LOS_THR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              bit_stb,
    input  logic [CH_W-1:0]   chan_idx,
    input  logic              rx_bit,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [CH_W-1:0]   win_start,
    input  logic [LEN_W-1:0]  win_len,
    input  logic              chk_en,
    input  logic              err_clr,
    output logic [CNT_W-1:0]  err_count
);
    localparam int LD_W = $clog2(PRBS_LEN + 1);

    pcw_state_e state_q, state_d;
    logic [LD_W-1:0] ld_q;
    logic in_win, take, load_stb, cmp_stb, mism, pred, los;

    pcw_window #(.CH_W(CH_W), .LEN_W(LEN_W), .RATE_W(RATE_W), .BASE(BASE_CHANS)) u_win (
        .chan_idx (chan_idx),
        .win_start(win_start),
        .win_len  (win_len),
        .rate_sel (rate_sel),
        .in_win   (in_win)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!chk_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_ARM;
                ST_ARM:   if (frame_pulse) state_d = ST_LOAD;
                ST_LOAD:  if (load_stb && (ld_q == LD_W'(PRBS_LEN - 1))) state_d = ST_TRACK;
                ST_TRACK: if (los) state_d = ST_LOAD;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        take     = bit_stb && in_win;
        load_stb = take && (state_q == ST_LOAD);
        cmp_stb  = take && (state_q == ST_TRACK);
        mism     = cmp_stb && (rx_bit != pred);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '0;
        end else if (state_q != ST_LOAD) begin
            ld_q <= '0;
        end else if (load_stb) begin
            ld_q <= ld_q + 1'b1;
        end
    end

    pcw_ref #(.W(PRBS_LEN), .TAP_A(PRBS_LEN - 1), .TAP_B(PRBS_LEN - 2)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (load_stb || cmp_stb),
        .load_mode(state_q == ST_LOAD),
        .rx_bit   (rx_bit),
        .pred     (pred)
    );

    pcw_loss #(.WIN(LOS_WIN), .THR(LOS_THR)) u_loss (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(state_q != ST_TRACK),
        .cmp_stb(cmp_stb),
        .mism   (mism),
        .los    (los)
    );

    pcw_errcnt #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (err_clr),
        .inc  (mism),
        .count(err_count)
    );
endmodule

// File: rtl/prbs_window_checker_sva.sv
module prbs_window_checker_sva
    import pcw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_en,
    input logic             err_clr,
    input logic             bit_stb,
    input logic [CNT_W-1:0] err_count,
    input pcw_state_e       state_q
);
    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (err_count == '0)); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_count == {CNT_W{1'b1}}) && !err_clr) |=> (err_count == {CNT_W{1'b1}})); // R8

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1))); // R7

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !err_clr) |=> $stable(err_count)); // R3

    AST_COUNT_ONLY_TRACKING: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_TRACK) && !err_clr) |=> $stable(err_count)); // R5

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> (state_q == ST_OFF)); // R2
endmodule

bind prbs_window_checker prbs_window_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (chk_en),
    .err_clr  (err_clr),
    .bit_stb  (bit_stb),
    .err_count(err_count),
    .state_q  (state_q)
);

// File: tb/prbs_window_checker_bench.sv
`timescale 1ns/1ps
module prbs_window_checker_bench;
    localparam int CW   = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_pulse = 1'b0;
    logic          bit_stb = 1'b0;
    logic [7:0]    chan_idx = '0;
    logic          rx_bit = 1'b0;
    logic [1:0]    rate_sel = '0;
    logic [7:0]    win_start = '0;
    logic [8:0]    win_len = '0;
    logic          chk_en = 1'b0;
    logic          err_clr = 1'b0;
    logic [CW-1:0] err_count;

    always #4 clk = ~clk;

    prbs_window_checker #(.CNT_W(CW)) u_prbs_window_checker (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .bit_stb(bit_stb),
        .chan_idx(chan_idx), .rx_bit(rx_bit), .rate_sel(rate_sel),
        .win_start(win_start), .win_len(win_len), .chk_en(chk_en),
        .err_clr(err_clr), .err_count(err_count)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    event  chk_ev;

    // Pattern source and reference model (0 off, 1 armed, 2 loading, 3 tracking)
    logic [14:0] g = 15'h1ACE;
    int          m_st = 0, m_ld = 0, m_blk = 0, m_berr = 0, m_cnt = 0;
    logic [14:0] m_reg = '0;

    function automatic logic gen_bit();
        logic nb;
        nb = g[14] ^ g[13];
        g  = {g[13:0], nb};
        return nb;
    endfunction

    task automatic model_bit(input logic b);
        logic p;
        if (m_st == 2) begin
            m_reg = {m_reg[13:0], b};
            m_ld++;
            if (m_ld == 15) begin m_st = 3; m_blk = 0; m_berr = 0; end
        end else if (m_st == 3) begin
            p = m_reg[14] ^ m_reg[13];
            m_reg = {m_reg[13:0], p};
            if (b != p) begin
                if (m_cnt < MAXC) m_cnt++;
                m_berr++;
            end
            m_blk++;
            if (m_berr >= 8) begin m_st = 2; m_ld = 0; m_blk = 0; m_berr = 0; end
            else if (m_blk == 64) begin m_blk = 0; m_berr = 0; end
        end
    endtask

    task automatic push_check(input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> chk_ev;
    endtask

    // mode 0: clean pattern, 1: clean with flips, 2: all ones
    task automatic run_frame(input int chans, input int mode, input int flip_every,
                             input int flip_max, input string tag);
        int nch, lo, hi, widx, flips;
        logic b;
        nch = 32 << rate_sel;
        lo  = win_start;
        hi  = lo + win_len;
        if (hi > nch) hi = nch;
        widx = 0; flips = 0;
        @(negedge clk);
        frame_pulse = 1'b1; bit_stb = 1'b0;
        if (m_st == 1) begin m_st = 2; m_ld = 0; end
        for (int c = 0; c < chans; c++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                frame_pulse = 1'b0; bit_stb = 1'b1; chan_idx = 8'(c);
                if (c >= lo && c < hi) begin
                    b = (mode == 2) ? 1'b1 : gen_bit();
                    if (mode == 1 && flip_every > 0 && (widx % flip_every) == flip_every - 1
                        && flips < flip_max) begin
                        b = ~b; flips++;
                    end
                    widx++;
                    rx_bit = b;
                    model_bit(b);
                end else begin
                    rx_bit = 1'($urandom);
                end
            end
        end
        @(negedge clk);
        bit_stb = 1'b0;
        push_check(m_cnt, tag);
    endtask

    task automatic pulse_clear(input string tag);
        @(negedge clk); err_clr = 1'b1; m_cnt = 0;
        @(negedge clk); err_clr = 1'b0;
        push_check(0, tag);
    endtask

    task automatic set_en(input logic en);
        @(negedge clk);
        chk_en = en;
        m_st = en ? 1 : 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: pops expected values and compares with the design
    initial begin
        forever begin
            int e; string t;
            @(chk_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (err_count !== CW'(e)) begin
                n_fail++;
                $display("FAIL %s: err_count=%0d expected=%0d", t, err_count, e);
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog (all): actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_check(0, "R1 reset count");

        // R2: disabled checker ignores a bad pattern
        rate_sel = 2'd0; win_start = 8'd2; win_len = 9'd4;
        run_frame(32, 2, 0, 0, "R2 disabled no count");

        set_en(1'b1);
        run_frame(32, 0, 0, 0, "R5 R6 clean lock");
        run_frame(32, 1, 5, 3, "R7 R3 three flips in window");
        run_frame(32, 0, 0, 0, "R11 pattern continues across frames");
        run_frame(32, 1, 2, 8, "R10 burst drops lock");
        run_frame(32, 0, 0, 0, "R10 relocked after reload");
        win_len = 9'd8;
        run_frame(32, 1, 8, 7, "R10 seven errors keep lock");
        pulse_clear("R9 clear");

        // R4: clamp at end of frame
        rate_sel = 2'd1; win_start = 8'd60; win_len = 9'd20;
        run_frame(70, 0, 0, 0, "R4 clamp rate1 clean");
        run_frame(70, 1, 4, 2, "R4 clamp rate1 two flips");
        rate_sel = 2'd0; win_start = 8'd28; win_len = 9'd10;
        run_frame(40, 0, 0, 0, "R4 clamp rate0 clean");

        // R3: zero length window
        win_start = 8'd5; win_len = 9'd0;
        run_frame(32, 2, 0, 0, "R3 zero length");

        // R8: saturation
        rate_sel = 2'd3; win_start = 8'd0; win_len = 9'd256;
        run_frame(256, 2, 0, 0, "R8 saturate");
        if (m_cnt != MAXC) begin
            n_fail++;
            $display("FAIL R8 bench model: actual=%0d expected=%0d", m_cnt, MAXC);
        end
        run_frame(256, 2, 0, 0, "R8 stays saturated");

        pulse_clear("R9 clear after saturation");
        set_en(1'b0);
        run_frame(256, 2, 0, 0, "R2 disabled again");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule